// File: doc/BRIEF.md
# Output Clock Gate with Register Control

This block sits between four free-running clock sources (two 27 MHz reference clocks, an audio clock and a video clock) and the four clock pins of the device. A serial slave elsewhere on the chip turns bus transactions into single-cycle register writes (address, data, strobe). The block decodes those writes into a run/stop state for each output and a global power mode. It gates each clock in that clock's own domain, so an output never shows a shortened pulse.

A stopped reference or audio output keeps driving and is held low. A stopped video output releases the pin: its output-enable goes low and its data is forced low behind it. Power-down stops all four outputs in their own stop styles. The individual run/stop settings are kept while powered down, so leaving power-down brings back whatever they last held. Clock synthesis is outside this block. Only gating, decoding and domain crossing live here.

Top module: `clkout_gate_top`

## Requirements
- R1: After reset every output follows its input clock with its output-enable high, and the power mode is active.
- R2: A write of 04h to address 64 (40h) lets the first reference output run. A write of 08h stops it.
- R3: Address 86 (56h) controls the audio output and address 96 (60h) controls the second reference output, each with 04h to run and 08h to stop.
- R4: A write of 00h to address 117 (75h) lets the video output run. A write of 04h stops it by driving its output-enable low, with its data held low.
- R5: A stopped reference or audio output keeps its output-enable high and drives a constant low level.
- R6: A write of 36h to address 29 (1Dh) enters power-down, which stops all four outputs in their own stop styles whatever their run settings hold. A write of 16h there returns to active mode and restores each output's stored setting.
- R7: A write carrying any code other than the defined ones for its address changes nothing. A write to any other address also changes nothing. This includes run/stop writes made during power-down, which are stored.
- R8: Run/stop changes take effect without a shortened pulse. An output rises only while its input clock is high, falls only while that clock is low, and every high pulse lasts a full input high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register write clock |
| cfg_rst_n | input | 1 | Asynchronous active-low reset for all domains |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| ref1_clk_i | input | 1 | First reference clock source |
| ref2_clk_i | input | 1 | Second reference clock source |
| aud_clk_i | input | 1 | Audio clock source |
| vid_clk_i | input | 1 | Video clock source |
| ref1_o | output | 1 | First reference clock pin data |
| ref1_oe | output | 1 | First reference pin output-enable |
| ref2_o | output | 1 | Second reference clock pin data |
| ref2_oe | output | 1 | Second reference pin output-enable |
| aud_o | output | 1 | Audio clock pin data |
| aud_oe | output | 1 | Audio pin output-enable |
| vid_o | output | 1 | Video clock pin data |
| vid_oe | output | 1 | Video pin output-enable (low when stopped) |

## Verification
Two functions can act on the same output in the same cycle: the power-down override and that output's own run/stop byte. A run/stop write made while power-down holds must be stored without showing at the pin. Leaving power-down must then expose the stored values together. The bench provokes this by writing an audio run code during power-down and judges it at the pins, both before and after the active-mode write. A second collision occurs between a run/stop change and the phase of the gated clock. Rapid toggles of the first reference and video enables at phases unrelated to their clocks provoke it, and the bench measures every high pulse width on those pins.

// File: rtl/clkout_gate_pkg.sv
`timescale 1ns/1ps
package clkout_gate_pkg;
   localparam int unsigned NUM_OUT = 4;
   localparam int unsigned ADDR_W  = 8;
   localparam int unsigned DATA_W  = 8;

   // Output slot order: 0 ref1, 1 ref2, 2 audio, 3 video
   localparam int unsigned IDX_REF1 = 0;
   localparam int unsigned IDX_REF2 = 1;
   localparam int unsigned IDX_AUD  = 2;
   localparam int unsigned IDX_VID  = 3;

   typedef enum logic { STOP_LOW = 1'b0, STOP_HIZ = 1'b1 } stop_style_e;

   localparam logic [ADDR_W-1:0] PWR_ADDR   = 8'h1D;
   localparam logic [DATA_W-1:0] PWR_ACTIVE = 8'h16;
   localparam logic [DATA_W-1:0] PWR_DOWN   = 8'h36;

   function automatic logic [ADDR_W-1:0] slot_addr(input int unsigned idx);
      case (idx)
         IDX_REF1: return 8'h40;
         IDX_REF2: return 8'h60;
         IDX_AUD:  return 8'h56;
         default:  return 8'h75;
      endcase
   endfunction

   function automatic logic [DATA_W-1:0] slot_run_code(input int unsigned idx);
      return (idx == IDX_VID) ? 8'h00 : 8'h04;
   endfunction

   function automatic logic [DATA_W-1:0] slot_stop_code(input int unsigned idx);
      return (idx == IDX_VID) ? 8'h04 : 8'h08;
   endfunction

   function automatic stop_style_e slot_style(input int unsigned idx);
      return (idx == IDX_VID) ? STOP_HIZ : STOP_LOW;
   endfunction
endpackage

// File: rtl/clkout_cfg_regs.sv
`timescale 1ns/1ps
module clkout_cfg_regs
   import clkout_gate_pkg::*;
#(
   parameter int unsigned N_OUT = NUM_OUT,
   parameter int unsigned AW    = ADDR_W,
   parameter int unsigned DW    = DATA_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [N_OUT-1:0] run_q,
   output logic          pd_q
);
   if (AW < 8) begin : g_bad_aw
      $error("clkout_cfg_regs: address width must hold 8-bit register numbers");
   end
   if (DW != 8) begin : g_bad_dw
      $error("clkout_cfg_regs: register bytes are 8 bits wide");
   end

   // One run flag per output; unknown codes leave the flag alone.
   for (genvar i = 0; i < N_OUT; i++) begin : g_slot
      localparam logic [AW-1:0] MY_ADDR = AW'(slot_addr(i));
      localparam logic [DW-1:0] MY_RUN  = DW'(slot_run_code(i));
      localparam logic [DW-1:0] MY_STOP = DW'(slot_stop_code(i));
      logic hit;
      assign hit = wr_en && (wr_addr == MY_ADDR);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          run_q[i] <= 1'b1;
         else if (hit && wr_data == MY_RUN)   run_q[i] <= 1'b1;
         else if (hit && wr_data == MY_STOP)  run_q[i] <= 1'b0;
      end
   end

   logic pwr_hit;
   assign pwr_hit = wr_en && (wr_addr == AW'(PWR_ADDR));
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             pd_q <= 1'b0;
      else if (pwr_hit && wr_data == PWR_DOWN)   pd_q <= 1'b1;
      else if (pwr_hit && wr_data == PWR_ACTIVE) pd_q <= 1'b0;
   end
endmodule

// File: rtl/clkout_sync.sv
`timescale 1ns/1ps
module clkout_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RST_VALUE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clkout_sync: at least two stages are needed");
   end

   logic [STAGES-1:0] chain;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VALUE}};
      else        chain <= {chain[STAGES-2:0], d};
   end
   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkout_gate_cell.sv
`timescale 1ns/1ps
module clkout_gate_cell
   import clkout_gate_pkg::*;
#(
   parameter stop_style_e STYLE       = STOP_LOW,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic run_async,
   output logic pin_o,
   output logic pin_oe
);
   logic run_sync;
   logic gate_q;

   clkout_sync #(.STAGES(SYNC_STAGES), .RST_VALUE(1'b1)) u_sync (
      .clk   (clk_i),
      .rst_n (rst_n),
      .d     (run_async),
      .q     (run_sync)
   );

   // The gate is updated on the falling edge, so it only moves while the clock is low.
   always_ff @(negedge clk_i or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b1;
      else        gate_q <= run_sync;
   end

   assign pin_o = clk_i & gate_q;

   if (STYLE == STOP_HIZ) begin : g_hiz
      assign pin_oe = gate_q;
   end else begin : g_low
      assign pin_oe = 1'b1;
   end
endmodule

// File: rtl/clkout_gate_top.sv
`timescale 1ns/1ps
module clkout_gate_top
   import clkout_gate_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              cfg_clk,
   input  logic              cfg_rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ref1_clk_i,
   input  logic              ref2_clk_i,
   input  logic              aud_clk_i,
   input  logic              vid_clk_i,
   output logic              ref1_o,
   output logic              ref1_oe,
   output logic              ref2_o,
   output logic              ref2_oe,
   output logic              aud_o,
   output logic              aud_oe,
   output logic              vid_o,
   output logic              vid_oe
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clkout_gate_top: SYNC_STAGES below two");
   end

   logic [NUM_OUT-1:0] run_q;
   logic               pd_q;
   logic [NUM_OUT-1:0] clk_vec;
   logic [NUM_OUT-1:0] pin_vec;
   logic [NUM_OUT-1:0] oe_vec;
   logic [NUM_OUT-1:0] run_eff;

   clkout_cfg_regs #(.N_OUT(NUM_OUT), .AW(ADDR_W), .DW(DATA_W)) u_regs (
      .clk     (cfg_clk),
      .rst_n   (cfg_rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .run_q   (run_q),
      .pd_q    (pd_q)
   );

   assign clk_vec = {vid_clk_i, aud_clk_i, ref2_clk_i, ref1_clk_i};
   assign run_eff = run_q & {NUM_OUT{~pd_q}};

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      clkout_gate_cell #(.STYLE(slot_style(i)), .SYNC_STAGES(SYNC_STAGES)) u_cell (
         .clk_i     (clk_vec[i]),
         .rst_n     (cfg_rst_n),
         .run_async (run_eff[i]),
         .pin_o     (pin_vec[i]),
         .pin_oe    (oe_vec[i])
      );
   end

   assign ref1_o  = pin_vec[IDX_REF1];
   assign ref1_oe = oe_vec[IDX_REF1];
   assign ref2_o  = pin_vec[IDX_REF2];
   assign ref2_oe = oe_vec[IDX_REF2];
   assign aud_o   = pin_vec[IDX_AUD];
   assign aud_oe  = oe_vec[IDX_AUD];
   assign vid_o   = pin_vec[IDX_VID];
   assign vid_oe  = oe_vec[IDX_VID];
endmodule

// File: rtl/clkout_gate_chk.sv
`timescale 1ns/1ps
module clkout_gate_chk (
   input logic       cfg_clk,
   input logic       cfg_rst_n,
   input logic       wr_en,
   input logic [7:0] wr_addr,
   input logic [7:0] wr_data,
   input logic [3:0] run_q,
   input logic       pd_q,
   input logic [3:0] clk_vec,
   input logic [3:0] pin_vec
);
   a_r2_ref1_stop: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (wr_en && wr_addr == 8'h40 && wr_data == 8'h08) |=> !run_q[0]);

   a_r4_vid_stop: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (wr_en && wr_addr == 8'h75 && wr_data == 8'h04) |=> !run_q[3]);

   a_r3_aud_run: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (wr_en && wr_addr == 8'h56 && wr_data == 8'h04) |=> run_q[2]);

   a_r6_pd_enter: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (wr_en && wr_addr == 8'h1D && wr_data == 8'h36) |=> pd_q);

   a_r6_pd_leave: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (wr_en && wr_addr == 8'h1D && wr_data == 8'h16) |=> !pd_q);

   a_r7_bad_code_keeps: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (wr_en && wr_addr == 8'h40 && wr_data != 8'h04 && wr_data != 8'h08)
      |=> $stable(run_q[0]));

   for (genvar i = 0; i < 4; i++) begin : g_edge
      always @(posedge pin_vec[i]) begin
         if (cfg_rst_n) a_r8_rise_in_high: assert (clk_vec[i]);
      end
      always @(negedge pin_vec[i]) begin
         if (cfg_rst_n) a_r8_fall_in_low: assert (!clk_vec[i]);
      end
   end
endmodule

bind clkout_gate_top clkout_gate_chk u_chk (
   .cfg_clk   (cfg_clk),
   .cfg_rst_n (cfg_rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .run_q     (run_q),
   .pd_q      (pd_q),
   .clk_vec   (clk_vec),
   .pin_vec   (pin_vec)
);

// File: tb/clkout_gate_top_tb.sv
`timescale 1ns/1ps
module clkout_gate_top_tb;
   logic cfg_clk = 1'b0, cfg_rst_n = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_addr = '0, wr_data = '0;
   logic ref1_clk = 1'b0, ref2_clk = 1'b0, aud_clk = 1'b0, vid_clk = 1'b0;
   logic ref1_o, ref1_oe, ref2_o, ref2_oe, aud_o, aud_oe, vid_o, vid_oe;

   int errors = 0, checks = 0;

   always #4    cfg_clk  = ~cfg_clk;   // 125 MHz
   always #18   ref1_clk = ~ref1_clk;
   always #19   ref2_clk = ~ref2_clk;
   always #11   aud_clk  = ~aud_clk;
   always #7    vid_clk  = ~vid_clk;

   clkout_gate_top u_dut (
      .cfg_clk(cfg_clk), .cfg_rst_n(cfg_rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .ref1_clk_i(ref1_clk), .ref2_clk_i(ref2_clk),
      .aud_clk_i(aud_clk), .vid_clk_i(vid_clk),
      .ref1_o(ref1_o), .ref1_oe(ref1_oe), .ref2_o(ref2_o), .ref2_oe(ref2_oe),
      .aud_o(aud_o), .aud_oe(aud_oe), .vid_o(vid_o), .vid_oe(vid_oe)
   );

   // Expected per-output state: 0 running, 1 held low driven, 2 released
   localparam logic [1:0] RN = 2'd0, LO = 2'd1, HZ = 2'd2;
   typedef struct packed {
      logic [7:0] addr;
      logic [7:0] data;
      logic [3:0] req;
      logic [1:0] vid, aud, ref2, ref1;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{8'h40, 8'h08, 4'd2, RN, RN, RN, LO},  // R2 stop ref1
      '{8'h56, 8'h08, 4'd3, RN, LO, RN, LO},  // R3 stop audio, R5 low
      '{8'h75, 8'h04, 4'd4, HZ, LO, RN, LO},  // R4 release video
      '{8'h60, 8'h08, 4'd3, HZ, LO, LO, LO},  // R3 stop ref2
      '{8'h40, 8'h04, 4'd2, HZ, LO, LO, RN},  // R2 run ref1
      '{8'h40, 8'h55, 4'd7, HZ, LO, LO, RN},  // R7 bad code
      '{8'h75, 8'h00, 4'd4, RN, LO, LO, RN},  // R4 run video
      '{8'h1D, 8'h36, 4'd6, HZ, LO, LO, LO},  // R6 power-down
      '{8'h56, 8'h04, 4'd7, HZ, LO, LO, LO},  // R7 stored, hidden by power-down
      '{8'h1D, 8'h16, 4'd6, RN, RN, LO, RN},  // R6 active restores
      '{8'h1E, 8'h08, 4'd7, RN, RN, LO, RN},  // R7 other address
      '{8'h1D, 8'h77, 4'd7, RN, RN, LO, RN},  // R7 bad power code
      '{8'h60, 8'h04, 4'd3, RN, RN, RN, RN},  // R3 run ref2
      '{8'h75, 8'h08, 4'd7, RN, RN, RN, RN}   // R7 stop code of others ignored by video
   };

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge cfg_clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge cfg_clk);
      wr_en = 1'b0;
   endtask

   // Observe all pins for 300 ns and compare with expected states.
   task automatic observe(input logic [1:0] e0, input logic [1:0] e1,
                          input logic [1:0] e2, input logic [1:0] e3,
                          input int req, input string tag);
      logic [1:0] exp_s [4];
      int hi_cnt [4], oe_hi [4], oe_lo [4];
      logic [3:0] p, oe;
      exp_s[0] = e0; exp_s[1] = e1; exp_s[2] = e2; exp_s[3] = e3;
      for (int k = 0; k < 4; k++) begin hi_cnt[k] = 0; oe_hi[k] = 0; oe_lo[k] = 0; end
      for (int t = 0; t < 600; t++) begin
         #0.5;
         p  = {vid_o, aud_o, ref2_o, ref1_o};
         oe = {vid_oe, aud_oe, ref2_oe, ref1_oe};
         for (int k = 0; k < 4; k++) begin
            if (p[k]) hi_cnt[k]++;
            if (oe[k]) oe_hi[k]++; else oe_lo[k]++;
         end
      end
      for (int k = 0; k < 4; k++) begin
         logic [1:0] got;
         if (oe_lo[k] == 600) got = HZ;
         else if (oe_hi[k] == 600 && hi_cnt[k] == 0) got = LO;
         else if (oe_hi[k] == 600 && hi_cnt[k] > 150 && hi_cnt[k] < 450) got = RN;
         else got = 2'd3;
         checks++;
         if (got !== exp_s[k]) begin
            errors++;
            $display("FAIL R%0d %s out%0d: actual state %0d expected %0d", req, tag, k, got, exp_s[k]);
         end
      end
   endtask

   // R8 pulse-width monitors on ref1 and video
   realtime r1_rise, v_rise;
   int short_pulses = 0;
   always @(posedge ref1_o) r1_rise = $realtime;
   always @(negedge ref1_o) if (cfg_rst_n && ($realtime - r1_rise) < 17.5) short_pulses++;
   always @(posedge vid_o)  v_rise = $realtime;
   always @(negedge vid_o)  if (cfg_rst_n && ($realtime - v_rise) < 6.5) short_pulses++;

   bit done = 1'b0;
   initial begin
      #150000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge cfg_clk);
      cfg_rst_n = 1'b1;
      #100;
      observe(RN, RN, RN, RN, 1, "R1 after reset");

      foreach (VEC[v]) begin
         write_reg(VEC[v].addr, VEC[v].data);
         #400;
         observe(VEC[v].ref1, VEC[v].ref2, VEC[v].aud, VEC[v].vid,
                 int'(VEC[v].req), $sformatf("vector %0d", v));
      end

      // R8: toggle ref1 and video at phases unrelated to their clocks
      for (int n = 0; n < 24; n++) begin
         write_reg(8'h40, (n % 2) ? 8'h04 : 8'h08);
         write_reg(8'h75, (n % 2) ? 8'h00 : 8'h04);
         #(13 + 7 * (n % 5));
      end
      #400;
      checks++;
      if (short_pulses != 0) begin
         errors++;
         $display("FAIL R8 short pulses: actual %0d expected 0", short_pulses);
      end
      observe(RN, RN, RN, RN, 8, "R8 after toggles");

      // R1: reset from a mixed stopped and powered-down state
      write_reg(8'h56, 8'h08);
      write_reg(8'h1D, 8'h36);
      #400;
      observe(LO, LO, LO, HZ, 6, "R6 before reset");
      @(negedge cfg_clk); cfg_rst_n = 1'b0;
      #40;
      @(negedge cfg_clk); cfg_rst_n = 1'b1;
      #100;
      observe(RN, RN, RN, RN, 1, "R1 reset clears stops");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule